// File: doc/BRIEF.md
# Two-Phase Buck Start-Up and Protection Sequencer

This block is the digital supervisor of a two-phase synchronous buck regulator. The analog side reaches it only as comparator bits. These bits report whether the supply is good, whether the reference pin is above its disable level, and whether that pin is strapped for the internal reference. Three more bits compare feedback against fixed fractions of the reference. A per-switching-cycle strobe paces all slow timing. From these inputs the block chooses the reference source and produces a 10-bit reference code for the DAC. That code comes from a digital soft-start ramp of one code step per switching cycle. The block also enables the master and slave phases, qualifies power-good and handles faults.

Faults are handled with a hiccup scheme. An overcurrent trip, or a low reading on the feedback undervoltage comparator after soft start has finished, turns both phases off. They stay off for a fixed interval, and then a fresh soft start runs. Overvoltage is handled apart from the sequence. It keeps every high-side enable low and every low-side enable high for as long as the comparator reports it.

All timing is in switching cycles, so the tick rate sets the ramp length and the hiccup interval. Every output is a register updated at the rising clock edge.

Top module: `buck_start_guard`

## Requirements
- R1: Both phases stay disabled (all four enables low when no overvoltage is present, ref_code 0) unless supply_ok and refin_live are both high. On the first edge at which both are high, the master phase enables (master_hi_en and master_lo_en become 1) and the ramp starts.
- R2: The slave enables follow the master enables only while slave_off is low. While slave_off is high, slave_hi_en and slave_lo_en stay low when no overvoltage is present, and the master is not affected.
- R3: The soft start begins at code 0 and raises ref_code by one on every tick, including the tick at the starting edge, so ref_code reads 1 after that edge. It stops at the target. ss_done rises on the edge that follows the 1024th ramp tick.
- R4: With refin_internal high the target is the all-ones code (1023). With refin_internal low the target is ext_ref_code. In either case ref_code moves toward the target by at most one code per tick, both during and after soft start.
- R5: pgood rises only in the run state (ss_done high), on the edge at which fb_pg has been sampled high on 6 consecutive ticks in that state. It falls on the first edge after fb_pg goes low or the run state is left.
- R6: ov_flag copies fb_ov one edge later. While it is set, master_hi_en and slave_hi_en are 0 and master_lo_en and slave_lo_en are 1 in every state, including off. The sequence state, ss_done and pgood do not change.
- R7: oc_trip during ramp or run enters hiccup on the next edge. At that edge hiccup_active goes to 1; ss_done, pgood, ref_code and, when no overvoltage is present, all four enables go to 0.
- R8: fb_uv_ok low enters hiccup only from the run state. During the ramp it has no effect.
- R9: After the entry edge, the phases stay off while 8192 ticks are counted. On the following edge a new ramp starts: hiccup_active goes to 0, master_hi_en goes to 1 and ref_code reads 1.
- R10: Reset is synchronous and active high. While it is held, every output is 0.
- R11: Loss of supply_ok or refin_live returns the block to the off state on the next edge from any state, and this aborts a hiccup interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-cycle strobe per switching period |
| supply_ok | input | 1 | Supply above its undervoltage threshold |
| refin_live | input | 1 | Reference pin above its disable level |
| refin_internal | input | 1 | Reference pin strapped high: use the internal reference |
| slave_off | input | 1 | High keeps the slave phase disabled |
| ext_ref_code | input | 10 | Digitised external reference target |
| fb_pg | input | 1 | Feedback above 75 % of reference |
| fb_uv_ok | input | 1 | Feedback above 70 % of reference |
| fb_ov | input | 1 | Feedback above 130 % of reference |
| oc_trip | input | 1 | Overcurrent comparator trip |
| ref_code | output | 10 | Reference code for the DAC |
| ss_done | output | 1 | Soft start complete (run state) |
| pgood | output | 1 | Qualified power good; gates the reference output buffer |
| ov_flag | output | 1 | Overvoltage indication |
| hiccup_active | output | 1 | Hiccup off interval in progress |
| master_hi_en | output | 1 | Master high-side enable |
| master_lo_en | output | 1 | Master low-side enable |
| slave_hi_en | output | 1 | Slave high-side enable |
| slave_lo_en | output | 1 | Slave low-side enable |

## Verification
A stimulus applied before an edge shows up at the outputs right after that edge. Enables, ov_flag, hiccup_active and ref_code steps all respond this way, so each check is sampled at the falling edge that follows. The slow results are counted from the edge that started them, with cyc_tick held high. ss_done is due on the 1024th edge after the ramp-start edge. pgood is due on the sixth edge in the run state, or the sixth edge after fb_pg returns. The ramp restarts on the 8193rd edge after hiccup entry. For each of these the bench checks the output one edge early, where the old value must still hold, and again on the due edge.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  typedef enum logic [1:0] {
    SEQ_OFF    = 2'd0,
    SEQ_RAMP   = 2'd1,
    SEQ_RUN    = 2'd2,
    SEQ_HICCUP = 2'd3
  } seq_state_t;
endpackage

// File: rtl/bsg_ref_slew.sv
// Reference code slewing toward a target by one code per tick, with a
// saturating count of ramp ticks that marks the end of soft start.
module bsg_ref_slew #(
  parameter int CODE_W     = 10,
  parameter int RAMP_STEPS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_zero,
  input  logic              tick,
  input  logic [CODE_W-1:0] target,
  output logic [CODE_W-1:0] code,
  output logic              ramp_done
);
  localparam int CNT_W = $clog2(RAMP_STEPS + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(RAMP_STEPS);

  logic [CNT_W-1:0] step_cnt;

  always_ff @(posedge clk) begin
    if (rst || hold_zero) begin
      code     <= '0;
      step_cnt <= '0;
    end else if (tick) begin
      if (code < target)
        code <= code + 1'b1;
      else if (code > target)
        code <= code - 1'b1;
      if (step_cnt != CNT_END)
        step_cnt <= step_cnt + 1'b1;
    end
  end

  assign ramp_done = (step_cnt == CNT_END);
endmodule

// File: rtl/bsg_tick_timer.sv
// Counts ticks while enabled; expired once LIMIT ticks have been counted.
module bsg_tick_timer #(
  parameter int LIMIT = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt <= '0;
    else if (tick && cnt != CNT_END)
      cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CNT_END);
endmodule

// File: rtl/bsg_pg_qual.sv
// Power-good qualifier: level must be seen on FILTER consecutive ticks
// while qualify is high; any low sample or loss of qualify clears it.
module bsg_pg_qual #(
  parameter int FILTER = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic qualify,
  input  logic tick,
  input  logic level,
  output logic good
);
  localparam int CNT_W = $clog2(FILTER + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FILTER);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!qualify || !level)
      cnt_d = '0;
    else if (tick && cnt_q != CNT_END)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      good  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      good  <= (cnt_d == CNT_END);
    end
  end
endmodule

// File: rtl/buck_start_guard.sv
module buck_start_guard #(
  parameter int CODE_W      = 10,
  parameter int RAMP_STEPS  = 1024,
  parameter int HICCUP_TICKS = 8192,
  parameter int PG_FILTER   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_tick,
  input  logic              supply_ok,
  input  logic              refin_live,
  input  logic              refin_internal,
  input  logic              slave_off,
  input  logic [CODE_W-1:0] ext_ref_code,
  input  logic              fb_pg,
  input  logic              fb_uv_ok,
  input  logic              fb_ov,
  input  logic              oc_trip,
  output logic [CODE_W-1:0] ref_code,
  output logic              ss_done,
  output logic              pgood,
  output logic              ov_flag,
  output logic              hiccup_active,
  output logic              master_hi_en,
  output logic              master_lo_en,
  output logic              slave_hi_en,
  output logic              slave_lo_en
);
  import bsg_pkg::*;

  localparam int N_PHASE = 2;
  localparam logic [CODE_W-1:0] FULL_CODE = {CODE_W{1'b1}};

  seq_state_t state_q, state_d;
  logic enable_ok, active_d, ramp_done, hic_expired;
  logic [CODE_W-1:0] target;
  logic [N_PHASE-1:0] allow, hi_q, lo_q;

  assign enable_ok = supply_ok & refin_live;
  assign target    = refin_internal ? FULL_CODE : ext_ref_code;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_OFF:    state_d = SEQ_RAMP;
      SEQ_RAMP:   if (oc_trip) state_d = SEQ_HICCUP;
                  else if (ramp_done) state_d = SEQ_RUN;
      SEQ_RUN:    if (oc_trip || !fb_uv_ok) state_d = SEQ_HICCUP;
      SEQ_HICCUP: if (hic_expired) state_d = SEQ_RAMP;
      default:    state_d = SEQ_OFF;
    endcase
    if (!enable_ok)
      state_d = SEQ_OFF;
  end

  assign active_d = (state_d == SEQ_RAMP) || (state_d == SEQ_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= SEQ_OFF;
      ss_done       <= 1'b0;
      hiccup_active <= 1'b0;
      ov_flag       <= 1'b0;
    end else begin
      state_q       <= state_d;
      ss_done       <= (state_d == SEQ_RUN);
      hiccup_active <= (state_d == SEQ_HICCUP);
      ov_flag       <= fb_ov;
    end
  end

  bsg_ref_slew #(.CODE_W(CODE_W), .RAMP_STEPS(RAMP_STEPS)) i_ramp (
    .clk       (clk),
    .rst       (rst),
    .hold_zero (!active_d),
    .tick      (cyc_tick),
    .target    (target),
    .code      (ref_code),
    .ramp_done (ramp_done)
  );

  bsg_tick_timer #(.LIMIT(HICCUP_TICKS)) i_hiccup (
    .clk     (clk),
    .rst     (rst),
    .clear   (state_q != SEQ_HICCUP),
    .tick    (cyc_tick),
    .expired (hic_expired)
  );

  bsg_pg_qual #(.FILTER(PG_FILTER)) i_pg (
    .clk     (clk),
    .rst     (rst),
    .qualify (state_d == SEQ_RUN),
    .tick    (cyc_tick),
    .level   (fb_pg),
    .good    (pgood)
  );

  // Phase 0 is the master, phase 1 the slave.
  assign allow[0] = active_d;
  assign allow[1] = active_d & ~slave_off;

  for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_q[p] <= 1'b0;
        lo_q[p] <= 1'b0;
      end else begin
        hi_q[p] <= allow[p] & ~fb_ov;
        lo_q[p] <= allow[p] | fb_ov;
      end
    end
  end

  assign master_hi_en = hi_q[0];
  assign master_lo_en = lo_q[0];
  assign slave_hi_en  = hi_q[1];
  assign slave_lo_en  = lo_q[1];
endmodule

// File: rtl/buck_start_guard_chk.sv
module buck_start_guard_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              fb_uv_ok,
  input logic              oc_trip,
  input logic [CODE_W-1:0] ref_code,
  input logic              ss_done,
  input logic              pgood,
  input logic              ov_flag,
  input logic              hiccup_active,
  input logic              master_hi_en,
  input logic              master_lo_en,
  input logic              slave_hi_en,
  input logic              slave_lo_en
);
  assert_slave_under_master_R2: assert property (@(posedge clk) disable iff (rst)
    slave_hi_en |-> master_hi_en);

  assert_ref_slew_R4: assert property (@(posedge clk) disable iff (rst)
    (master_hi_en && $past(master_hi_en)) |->
      ((ref_code == $past(ref_code)) || (ref_code == $past(ref_code) + 1'b1) ||
       (ref_code + 1'b1 == $past(ref_code))));

  assert_pgood_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
    pgood |-> ss_done);

  assert_ov_override_R6: assert property (@(posedge clk) disable iff (rst)
    ov_flag |-> (!master_hi_en && !slave_hi_en && master_lo_en && slave_lo_en));

  assert_hiccup_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    hiccup_active |-> (ref_code == '0 && !master_hi_en && !slave_hi_en && !ss_done));

  assert_hiccup_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(hiccup_active) |-> ($past(oc_trip) || ($past(ss_done) && !$past(fb_uv_ok))));
endmodule

bind buck_start_guard buck_start_guard_chk #(.CODE_W(CODE_W)) i_chk (.*);

// File: tb/test_buck_start_guard.sv
module test_buck_start_guard;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst, cyc_tick, supply_ok, refin_live, refin_internal, slave_off;
  logic [CW-1:0] ext_ref_code;
  logic fb_pg, fb_uv_ok, fb_ov, oc_trip;
  logic [CW-1:0] ref_code;
  logic ss_done, pgood, ov_flag, hiccup_active;
  logic master_hi_en, master_lo_en, slave_hi_en, slave_lo_en;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_start_guard i_buck_start_guard (.*);

  // {slave_off, fb_ov, exp master_hi, master_lo, slave_hi, slave_lo, ov_flag}
  localparam logic [6:0] VEC [0:4] = '{
    7'b0011110, 7'b1011000, 7'b0101011, 7'b1101011, 7'b0011110
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; cyc_tick = 1; supply_ok = 0; refin_live = 1; refin_internal = 1;
    slave_off = 1; ext_ref_code = '0; fb_pg = 1; fb_uv_ok = 1; fb_ov = 0; oc_trip = 0;
    step(3);
    chk("R10 reset outputs", {ref_code, ss_done, pgood, ov_flag, hiccup_active,
        master_hi_en, master_lo_en, slave_hi_en, slave_lo_en}, 0);
    rst = 0;
    step(3);
    chk("R1 off without supply", {master_hi_en, master_lo_en, 22'(ref_code)}, 0);
    supply_ok = 1; refin_live = 0;
    step(2);
    chk("R1 off with refin low", {master_hi_en, master_lo_en}, 0);
    refin_live = 1;
    step(1);                                  // edge S
    chk("R1 master on", {master_hi_en, master_lo_en}, 3);
    chk("R3 first ramp code", ref_code, 1);
    chk("R2 slave held off", {slave_hi_en, slave_lo_en}, 0);
    fb_uv_ok = 0;
    step(2);                                  // S+2
    chk("R8 uv ignored in ramp", {hiccup_active, master_hi_en}, 1);
    chk("R3 ramp code S+2", ref_code, 3);
    fb_uv_ok = 1;
    step(507);                                // S+509
    chk("R3 ramp code mid", ref_code, 510);
    step(513);                                // S+1022
    chk("R3 ramp reaches full", ref_code, 1023);
    step(1);                                  // S+1023
    chk("R3 ss_done not yet", ss_done, 0);
    step(1);                                  // S+1024
    chk("R3 ss_done set", ss_done, 1);
    chk("R3 clamp at target", ref_code, 1023);
    chk("R5 pgood not yet", pgood, 0);
    step(4);                                  // S+1028
    chk("R5 pgood before filter", pgood, 0);
    step(1);                                  // S+1029
    chk("R5 pgood after 6 ticks", pgood, 1);

    for (int i = 0; i < 5; i++) begin
      slave_off = VEC[i][6]; fb_ov = VEC[i][5];
      step(1);
      chk($sformatf("R2/R6 vector %0d enables", i),
          {master_hi_en, master_lo_en, slave_hi_en, slave_lo_en, ov_flag}, VEC[i][4:0]);
      chk($sformatf("R6 vector %0d state kept", i), {ss_done, pgood}, 3);
    end

    fb_pg = 0;
    step(1);
    chk("R5 pgood drops", pgood, 0);
    fb_pg = 1;
    step(5);
    chk("R5 pgood requalify pending", pgood, 0);
    step(1);
    chk("R5 pgood requalified", pgood, 1);

    refin_internal = 0; ext_ref_code = 10'd1000;
    step(1);
    chk("R4 external slews down", ref_code, 1022);
    step(22);
    chk("R4 reaches external", ref_code, 1000);
    step(3);
    chk("R4 holds external", ref_code, 1000);
    ext_ref_code = 10'd1010;
    step(5);
    chk("R4 slews up", ref_code, 1005);
    chk("R4 run kept", ss_done, 1);
    refin_internal = 1;

    fb_uv_ok = 0;
    step(1);                                  // edge H
    chk("R8 uv in run -> hiccup", hiccup_active, 1);
    chk("R7 hiccup outputs", {master_hi_en, master_lo_en, slave_hi_en, slave_lo_en,
        ss_done, pgood, 10'(ref_code)}, 0);
    fb_uv_ok = 1;
    step(8191);
    chk("R9 still off", {master_hi_en, hiccup_active}, 1);
    step(1);                                  // H+8192
    chk("R9 off at limit", {master_hi_en, hiccup_active}, 1);
    step(1);                                  // H+8193
    chk("R9 restart", {master_hi_en, hiccup_active}, 2);
    chk("R9 restart code", ref_code, 1);

    oc_trip = 1;
    step(1);
    chk("R7 oc in ramp", {hiccup_active, master_hi_en, master_lo_en}, 4);
    chk("R7 code cleared", ref_code, 0);
    oc_trip = 0;
    step(3);
    refin_live = 0;
    step(1);
    chk("R11 abort hiccup", {hiccup_active, master_hi_en, master_lo_en}, 0);
    fb_ov = 1;
    step(1);
    chk("R6 ov while off", {master_hi_en, master_lo_en, slave_hi_en, slave_lo_en, ov_flag}, 5'b01011);
    fb_ov = 0;
    step(1);
    chk("R6 ov released", {master_lo_en, slave_lo_en, ov_flag}, 0);
    refin_live = 1;
    step(1);
    chk("R1 re-enable", {master_hi_en, slave_hi_en}, 3);
    chk("R3 ramp from zero", ref_code, 1);
    finish_run();
  end
endmodule